// File: doc/BRIEF.md
# Lockable Tile Scratch Memory

This block is an on-chip scratch store for pixel data. It holds four independent buffers of 64-bit vector entries. One request port selects a buffer and a 10-bit entry offset and asks for a read or a write on behalf of a thread group. A read returns the entry one cycle later.

Every entry also carries an ownership lock. A read can take the lock for its group. From then on only that group may touch the entry. A write by the owner can hand the lock back. The lock never times out and is cleared only by a release or by reset.

Every request gets a response in the following cycle. The response says whether the access was granted or blocked. A blocked access leaves both the data and the lock as they were.

Top module: `tbm_top`

## Requirements
- R1: The store holds 4 buffers, each of 1024 entries of 64 bits. An entry is chosen by `req_buf` (0..3) and `req_off` (0..1023). The same offset in different buffers names different entries with independent data and locks.
- R2: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high, and low otherwise.
- R3: A granted read returns the stored entry on `rsp_rdata` in the response cycle. A read issued in the cycle right after a granted write to the same entry returns the newly written data.
- R4: `rsp_granted` is 1 for a granted access and 0 for a blocked one. `rsp_rdata` is zero for every write response, for every blocked response and when `rsp_valid` is low.
- R5: A read with `req_acquire` set on an unlocked entry is granted. It locks the entry and records `req_group` as the owner.
- R6: While an entry is locked, any access from a different group is blocked. This covers plain reads, reads with acquire, writes and writes with release. A blocked access writes no data and leaves the lock and the owner unchanged.
- R7: A read with acquire by the owning group on an entry it already holds is granted, and the entry stays locked.
- R8: A granted write by the owner without `req_release` keeps the lock. With `req_release` set, it clears the lock after storing the data.
- R9: `req_release` on a write to an unlocked entry is granted and has no lock effect. `req_release` on a read has no effect. `req_acquire` on a write has no effect.
- R10: A lock stays held through any number of idle cycles. Reset clears every lock and drives `rsp_valid`, `rsp_granted` and `rsp_rdata` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_buf | input | 2 | Buffer select |
| req_off | input | 10 | Entry offset within the buffer |
| req_write | input | 1 | 1 = write, 0 = read |
| req_group | input | 6 | Requesting thread group ID |
| req_acquire | input | 1 | On a read: take the entry lock |
| req_release | input | 1 | On a write: drop the entry lock |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_granted | output | 1 | 1 = granted, 0 = blocked |
| rsp_rdata | output | 64 | Read data for granted reads, else zero |

## Verification
The hardest situation to reach from the ports is a blocked write that must leave no trace. Proving this needs a lock held by one group, a write attempt from a second group, and then a read-back through the owner. The bench builds that chain in its vector table: a group first takes a lock, other groups then try writes, releases and acquires on the same entry, and the owner reads back to show the data was untouched. A directed phase then leaves a lock idle for many cycles and confirms it still blocks. It then applies reset in the middle of the run and confirms that the formerly blocked group is granted.

// File: rtl/tbm_pkg.sv
package tbm_pkg;
    localparam int TBM_NUM_BUFS  = 4;
    localparam int TBM_BUF_DEPTH = 1024;
    localparam int TBM_DATA_W    = 64;
    localparam int TBM_GROUP_W   = 6;

    typedef enum logic {
        TBM_BLOCKED = 1'b0,
        TBM_GRANTED = 1'b1
    } tbm_status_e;
endpackage

// File: rtl/tbm_lock_table.sv
module tbm_lock_table #(
    parameter int ENTRIES = 4096,
    parameter int IDX_W   = 12,
    parameter int GROUP_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lk_valid,
    input  logic [IDX_W-1:0]   lk_idx,
    input  logic               lk_write,
    input  logic [GROUP_W-1:0] lk_group,
    input  logic               lk_acquire,
    input  logic               lk_release,
    output logic               lk_grant
);
    typedef struct packed {
        logic               held;
        logic [GROUP_W-1:0] owner;
    } lock_ent_t;

    typedef struct packed {
        logic             en;
        logic [IDX_W-1:0] idx;
        lock_ent_t        ent;
    } lock_upd_t;

    lock_ent_t tab_q [ENTRIES];
    lock_ent_t cur;
    lock_upd_t upd_d;
    logic      foreign;

    always_comb begin
        cur       = tab_q[lk_idx];
        foreign   = cur.held && (cur.owner != lk_group);
        lk_grant  = !foreign;
        upd_d     = '0;
        upd_d.idx = lk_idx;
        upd_d.ent = cur;
        if (lk_valid && !foreign) begin
            if (!lk_write && lk_acquire) begin
                upd_d.en        = 1'b1;
                upd_d.ent.held  = 1'b1;
                upd_d.ent.owner = lk_group;
            end else if (lk_write && lk_release && cur.held) begin
                upd_d.en       = 1'b1;
                upd_d.ent.held = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                tab_q[i] <= '0;
            end
        end else if (upd_d.en) begin
            tab_q[upd_d.idx] <= upd_d.ent;
        end
    end
endmodule

// File: rtl/tbm_data_bank.sv
module tbm_data_bank #(
    parameter int DEPTH  = 1024,
    parameter int ADDR_W = 10,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[addr] <= wdata;
        end
        if (rd_en) begin
            rdata_q <= mem[addr];
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/tbm_top.sv
module tbm_top
    import tbm_pkg::*;
#(
    parameter int NUM_BUFS  = TBM_NUM_BUFS,
    parameter int BUF_DEPTH = TBM_BUF_DEPTH,
    parameter int DATA_W    = TBM_DATA_W,
    parameter int GROUP_W   = TBM_GROUP_W,
    localparam int BUF_W    = $clog2(NUM_BUFS),
    localparam int OFF_W    = $clog2(BUF_DEPTH),
    localparam int IDX_W    = BUF_W + OFF_W,
    localparam int ENTRIES  = NUM_BUFS * BUF_DEPTH
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [BUF_W-1:0]   req_buf,
    input  logic [OFF_W-1:0]   req_off,
    input  logic               req_write,
    input  logic [GROUP_W-1:0] req_group,
    input  logic               req_acquire,
    input  logic               req_release,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               rsp_valid,
    output logic               rsp_granted,
    output logic [DATA_W-1:0]  rsp_rdata
);
    typedef struct packed {
        logic             valid;
        tbm_status_e      status;
        logic             is_rd;
        logic [BUF_W-1:0] bsel;
    } rsp_st_t;

    rsp_st_t           rsp_d, rsp_q;
    logic              grant;
    logic              wr_ok, rd_ok;
    logic [DATA_W-1:0] bank_rd [NUM_BUFS];

    tbm_lock_table #(
        .ENTRIES (ENTRIES),
        .IDX_W   (IDX_W),
        .GROUP_W (GROUP_W)
    ) lock_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_valid   (req_valid),
        .lk_idx     ({req_buf, req_off}),
        .lk_write   (req_write),
        .lk_group   (req_group),
        .lk_acquire (req_acquire),
        .lk_release (req_release),
        .lk_grant   (grant)
    );

    assign wr_ok = req_valid && grant && req_write;
    assign rd_ok = req_valid && grant && !req_write;

    for (genvar g = 0; g < NUM_BUFS; g++) begin : g_bank
        logic sel;
        assign sel = (req_buf == BUF_W'(g));
        tbm_data_bank #(
            .DEPTH  (BUF_DEPTH),
            .ADDR_W (OFF_W),
            .DATA_W (DATA_W)
        ) bank_i (
            .clk   (clk),
            .wr_en (wr_ok && sel),
            .rd_en (rd_ok && sel),
            .addr  (req_off),
            .wdata (req_wdata),
            .rdata (bank_rd[g])
        );
    end

    always_comb begin
        rsp_d        = '0;
        rsp_d.valid  = req_valid;
        rsp_d.status = (req_valid && grant) ? TBM_GRANTED : TBM_BLOCKED;
        rsp_d.is_rd  = req_valid && !req_write;
        rsp_d.bsel   = req_buf;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid   = rsp_q.valid;
    assign rsp_granted = rsp_q.valid && (rsp_q.status == TBM_GRANTED);
    assign rsp_rdata   = (rsp_granted && rsp_q.is_rd) ? bank_rd[rsp_q.bsel] : '0;
endmodule

// File: rtl/tbm_top_chk.sv
module tbm_top_chk #(
    parameter int BUF_W   = 2,
    parameter int OFF_W   = 10,
    parameter int DATA_W  = 64,
    parameter int GROUP_W = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [BUF_W-1:0]   req_buf,
    input logic [OFF_W-1:0]   req_off,
    input logic               req_write,
    input logic [GROUP_W-1:0] req_group,
    input logic               req_acquire,
    input logic               rsp_valid,
    input logic               rsp_granted,
    input logic [DATA_W-1:0]  rsp_rdata
);
    typedef struct packed {
        logic                     v;
        logic                     w;
        logic                     a;
        logic [BUF_W+OFF_W-1:0]   idx;
        logic [GROUP_W-1:0]       grp;
    } seen_t;

    seen_t r1, r2;
    logic  last_grant;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r1         <= '0;
            r2         <= '0;
            last_grant <= 1'b0;
        end else begin
            r1         <= '{req_valid, req_write, req_acquire, {req_buf, req_off}, req_group};
            r2         <= r1;
            last_grant <= rsp_granted;
        end
    end

    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R2
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R4
    blocked_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_granted) |-> (rsp_rdata == '0));

    // R4
    write_rsp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && r1.v && r1.w) |-> (rsp_rdata == '0));

    // R6
    foreign_after_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r2.v && !r2.w && r2.a && last_grant && r1.v &&
         r1.idx == r2.idx && r1.grp != r2.grp) |-> (rsp_valid && !rsp_granted));
endmodule

bind tbm_top tbm_top_chk #(
    .BUF_W   (BUF_W),
    .OFF_W   (OFF_W),
    .DATA_W  (DATA_W),
    .GROUP_W (GROUP_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_buf     (req_buf),
    .req_off     (req_off),
    .req_write   (req_write),
    .req_group   (req_group),
    .req_acquire (req_acquire),
    .rsp_valid   (rsp_valid),
    .rsp_granted (rsp_granted),
    .rsp_rdata   (rsp_rdata)
);

// File: tb/tbm_top_tb_top.sv
`timescale 1ns/1ps
module tbm_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [1:0]  req_buf;
    logic [9:0]  req_off;
    logic        req_write;
    logic [5:0]  req_group;
    logic        req_acquire;
    logic        req_release;
    logic [63:0] req_wdata;
    logic        rsp_valid;
    logic        rsp_granted;
    logic [63:0] rsp_rdata;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    tbm_top dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_buf     (req_buf),
        .req_off     (req_off),
        .req_write   (req_write),
        .req_group   (req_group),
        .req_acquire (req_acquire),
        .req_release (req_release),
        .req_wdata   (req_wdata),
        .rsp_valid   (rsp_valid),
        .rsp_granted (rsp_granted),
        .rsp_rdata   (rsp_rdata)
    );

    typedef struct packed {
        logic        v;
        logic        w;
        logic [1:0]  b;
        logic [9:0]  off;
        logic [5:0]  g;
        logic        a;
        logic        r;
        logic [63:0] d;
        logic        eg;
        logic [63:0] ed;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t TBL [NV] = '{
        // R3 write then read back
        '{1'b1,1'b1,2'd0,10'd5,   6'd1,1'b0,1'b0,64'h1111_2222_3333_4444,1'b1,64'h0,4'd3},
        '{1'b1,1'b0,2'd0,10'd5,   6'd1,1'b0,1'b0,64'h0,1'b1,64'h1111_2222_3333_4444,4'd3},
        // R1 same offset, other buffer
        '{1'b1,1'b1,2'd1,10'd5,   6'd2,1'b0,1'b0,64'hBBBB_0000_CCCC_0001,1'b1,64'h0,4'd1},
        '{1'b1,1'b0,2'd0,10'd5,   6'd3,1'b0,1'b0,64'h0,1'b1,64'h1111_2222_3333_4444,4'd1},
        '{1'b1,1'b0,2'd1,10'd5,   6'd3,1'b0,1'b0,64'h0,1'b1,64'hBBBB_0000_CCCC_0001,4'd1},
        // R5 acquire at top offset
        '{1'b1,1'b1,2'd2,10'd1023,6'd4,1'b0,1'b0,64'hC0C0_C0C0_0000_1023,1'b1,64'h0,4'd5},
        '{1'b1,1'b0,2'd2,10'd1023,6'd4,1'b1,1'b0,64'h0,1'b1,64'hC0C0_C0C0_0000_1023,4'd5},
        // R6 foreign write, read, acquire blocked
        '{1'b1,1'b1,2'd2,10'd1023,6'd5,1'b0,1'b0,64'hDEAD_DEAD_DEAD_DEAD,1'b0,64'h0,4'd6},
        '{1'b1,1'b0,2'd2,10'd1023,6'd5,1'b0,1'b0,64'h0,1'b0,64'h0,4'd6},
        '{1'b1,1'b0,2'd2,10'd1023,6'd5,1'b1,1'b0,64'h0,1'b0,64'h0,4'd6},
        // R7 owner re-acquire, data untouched by blocked write
        '{1'b1,1'b0,2'd2,10'd1023,6'd4,1'b1,1'b0,64'h0,1'b1,64'hC0C0_C0C0_0000_1023,4'd7},
        '{1'b1,1'b0,2'd2,10'd1023,6'd4,1'b0,1'b0,64'h0,1'b1,64'hC0C0_C0C0_0000_1023,4'd6},
        // R6 foreign release blocked
        '{1'b1,1'b1,2'd2,10'd1023,6'd5,1'b0,1'b1,64'hFFFF_0000_FFFF_0000,1'b0,64'h0,4'd6},
        // R8 owner write keeps lock
        '{1'b1,1'b1,2'd2,10'd1023,6'd4,1'b0,1'b0,64'hEEEE_0000_0000_0001,1'b1,64'h0,4'd8},
        '{1'b1,1'b1,2'd2,10'd1023,6'd6,1'b0,1'b0,64'hF0F0_F0F0_F0F0_F0F0,1'b0,64'h0,4'd8},
        // R8 owner write with release frees it
        '{1'b1,1'b1,2'd2,10'd1023,6'd4,1'b0,1'b1,64'h6666_0000_0000_0002,1'b1,64'h0,4'd8},
        '{1'b1,1'b1,2'd2,10'd1023,6'd6,1'b0,1'b0,64'h8888_0000_0000_0003,1'b1,64'h0,4'd8},
        '{1'b1,1'b0,2'd2,10'd1023,6'd6,1'b0,1'b0,64'h0,1'b1,64'h8888_0000_0000_0003,4'd8},
        // R9 release on unlocked write has no lock effect
        '{1'b1,1'b1,2'd3,10'd0,   6'd7,1'b0,1'b1,64'h1234_5678_9ABC_DEF0,1'b1,64'h0,4'd9},
        '{1'b1,1'b0,2'd3,10'd0,   6'd8,1'b1,1'b0,64'h0,1'b1,64'h1234_5678_9ABC_DEF0,4'd9},
        '{1'b1,1'b1,2'd3,10'd0,   6'd7,1'b0,1'b0,64'h5555_5555_5555_5555,1'b0,64'h0,4'd6},
        '{1'b1,1'b0,2'd3,10'd0,   6'd8,1'b0,1'b0,64'h0,1'b1,64'h1234_5678_9ABC_DEF0,4'd6},
        // R9 release on read ignored
        '{1'b1,1'b0,2'd3,10'd0,   6'd8,1'b0,1'b1,64'h0,1'b1,64'h1234_5678_9ABC_DEF0,4'd9},
        '{1'b1,1'b1,2'd3,10'd0,   6'd7,1'b0,1'b0,64'h7777_7777_7777_7777,1'b0,64'h0,4'd9},
        // R9 acquire on write ignored
        '{1'b1,1'b1,2'd1,10'd7,   6'd9,1'b1,1'b0,64'h0000_0000_0000_0A0A,1'b1,64'h0,4'd9},
        '{1'b1,1'b1,2'd1,10'd7,   6'd10,1'b0,1'b0,64'h0000_0000_0000_0B0B,1'b1,64'h0,4'd9},
        '{1'b1,1'b0,2'd1,10'd7,   6'd10,1'b0,1'b0,64'h0,1'b1,64'h0000_0000_0000_0B0B,4'd9},
        // R2 idle cycle: no response
        '{1'b0,1'b0,2'd0,10'd0,   6'd0,1'b0,1'b0,64'h0,1'b0,64'h0,4'd2},
        // R1 lock is per buffer
        '{1'b1,1'b1,2'd0,10'd0,   6'd7,1'b0,1'b0,64'h0F0F_0F0F_0F0F_0F0F,1'b1,64'h0,4'd1},
        '{1'b1,1'b0,2'd0,10'd0,   6'd7,1'b0,1'b0,64'h0,1'b1,64'h0F0F_0F0F_0F0F_0F0F,4'd1}
    };

    task automatic check(input string what, input int rq, input logic ev,
                         input logic eg, input logic [63:0] ed);
        n_cmp++;
        if (rsp_valid !== ev || (ev && rsp_granted !== eg) || rsp_rdata !== ed) begin
            n_bad++;
            $display("FAIL R%0d %s: got valid=%b granted=%b rdata=%h, expected valid=%b granted=%b rdata=%h",
                     rq, what, rsp_valid, rsp_granted, rsp_rdata, ev, eg, ed);
        end
    endtask

    task automatic drive(input vec_t t);
        req_valid   = t.v;
        req_write   = t.w;
        req_buf     = t.b;
        req_off     = t.off;
        req_group   = t.g;
        req_acquire = t.a;
        req_release = t.r;
        req_wdata   = t.d;
    endtask

    task automatic run(input vec_t t, input string what);
        drive(t);
        @(posedge clk);
        @(negedge clk);
        check(what, int'(t.req), t.v, t.eg, t.ed);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        vec_t idle;
        idle = '0;
        drive(idle);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R10 reset state
        check("reset outputs", 10, 1'b0, 1'b0, 64'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            run(TBL[i], $sformatf("vector %0d", i));
        end

        // R10 lock on buffer 3 offset 0 (owner 8) held across idle cycles
        drive(idle);
        repeat (60) @(negedge clk);
        check("idle no response", 2, 1'b0, 1'b0, 64'h0);
        run('{1'b1,1'b1,2'd3,10'd0,6'd7,1'b0,1'b0,64'h9999_0000_0000_9999,1'b0,64'h0,4'd10},
            "lock held after idle");

        // R10 reset clears locks
        drive(idle);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("outputs in reset", 10, 1'b0, 1'b0, 64'h0);
        rst_n = 1'b1;
        run('{1'b1,1'b1,2'd3,10'd0,6'd7,1'b0,1'b0,64'hABCD_0000_0000_ABCD,1'b1,64'h0,4'd10},
            "write after reset granted");
        run('{1'b1,1'b0,2'd3,10'd0,6'd7,1'b0,1'b0,64'h0,1'b1,64'hABCD_0000_0000_ABCD,4'd10},
            "read after reset");
        // R5 acquire again, then a foreign plain read is blocked
        run('{1'b1,1'b0,2'd3,10'd0,6'd11,1'b1,1'b0,64'h0,1'b1,64'hABCD_0000_0000_ABCD,4'd5},
            "acquire after reset");
        run('{1'b1,1'b0,2'd3,10'd0,6'd12,1'b0,1'b0,64'h0,1'b0,64'h0,4'd6},
            "foreign read blocked");

        drive(idle);
        @(negedge clk);
        finish_run();
    end
endmodule